// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block lets synchronous logic use an external byte-wide asynchronous static RAM. The RAM has a 19-bit address and active-low chip, output and write strobes. A host asks for one read or one write at a time over a request/acknowledge pair. The sequencer registers the address and the write byte, then drives the memory strobes through a fixed series of phases. Each phase lasts a whole number of clock cycles. For a read, it samples the returned byte and hands it back together with a one-cycle acknowledge.

Every phase length is worked out at elaboration time. The inputs are the clock period and the memory's nanosecond limits: access times, write pulse, address-to-strobe-release, data setup and hold, address hold, minimum cycle and output release. Each limit becomes `max(1, ceil(ns / period))` cycles. The shared data bus is split into an input byte, an output byte and an output-enable. An external power-fail hold input stops new accesses from being accepted. An access that has already started always finishes.

Top module: `async_sram_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, memCeN, memOeN and memWeN are 1, memDoutEn is 0 and hostAck is 0. hostReady is 1 while pwrHold is 0.
- R2: A read (hostWr=0) keeps memCeN=0, memOeN=0 and memWeN=1 for exactly RD_CYC cycles. RD_CYC = max(cycles(T_ACC_NS), cycles(T_OE_ACC_NS), cycles(T_CYC_NS)); with the defaults this is 7. memDin is sampled at the clock edge that ends this window. hostAck rises RD_CYC+1 cycles after the accept edge.
- R3: A write (hostWr=1) keeps memCeN=0 and memWeN=0 for exactly WR_CYC cycles, with memDoutEn=1. WR_CYC = max(cycles(T_WP_NS), cycles(T_AW_NS), cycles(T_DW_NS), cycles(T_CYC_NS)-HOLD_CYC); with the defaults this is 7. memOeN is 1 in every cycle where memWeN is 0 or memDoutEn is 1.
- R4: After memWeN rises, memDoutEn stays 1 for exactly HOLD_CYC cycles, with memCeN=1. HOLD_CYC = max(cycles(T_DH_NS), cycles(T_AH_NS)).
- R5: memAddr does not change during any run of consecutive cycles in which memCeN=0 or memDoutEn=1.
- R6: After memOeN rises, memDoutEn stays 0 for at least TURN_CYC = cycles(T_OHZ_NS) cycles.
- R7: A request is accepted only on a clock edge where hostReq=1 and hostReady=1. hostReady is 1 only when the sequencer is idle and pwrHold=0. A request made while hostReady=0 leaves the memory untouched.
- R8: Raising pwrHold after a request has been accepted does not shorten or stop that access. Its acknowledge still arrives at the normal latency.
- R9: hostAck is high for exactly one cycle per access. On a read, hostRdata shows the sampled byte in that same cycle.
- R10: A timing of 0 ns still gives a one-cycle phase. With the defaults, a write acknowledges WR_CYC+HOLD_CYC+1 = 9 cycles after the accept edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostReq | input | 1 | Access request |
| hostWr | input | 1 | 1 = write, 0 = read |
| hostAddr | input | 19 | Access address |
| hostWdata | input | 8 | Write byte |
| pwrHold | input | 1 | Power-fail hold; refuses new requests |
| hostReady | output | 1 | A request would be accepted this cycle |
| hostAck | output | 1 | One-cycle completion pulse |
| hostRdata | output | 8 | Read byte, valid with hostAck |
| memAddr | output | 19 | Memory address |
| memDout | output | 8 | Byte driven towards memory |
| memDoutEn | output | 1 | Data bus drive enable |
| memDin | input | 8 | Byte returned by memory |
| memCeN | output | 1 | Chip enable, active low |
| memOeN | output | 1 | Output enable, active low |
| memWeN | output | 1 | Write enable, active low |

## Verification
A phase counter that is off by one shows up at the pins in the same access. The strobe-low width changes, and the acknowledge latency moves by one cycle. A read sampled too early returns a filler byte from the bench's memory model, which only gives real data once the enables have been low long enough. A wrong state transition can leave memOeN low during a write, move the address in mid-cycle, or start driving the bus too soon after a read. Each of these is visible in the next cycle. A state that is lost during a power-fail hold shows up as a missing acknowledge, or as a byte that was never stored when it is read back.

// File: rtl/async_sram_seq_pkg.sv
package async_sram_seq_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD_ACC,
    S_RD_TURN,
    S_WR_PULSE,
    S_WR_HOLD
  } seqState_t;

  // Strobes from control to datapath. Pin fields describe the next state.
  typedef struct packed {
    logic load;
    logic ceN;
    logic oeN;
    logic weN;
    logic drive;
    logic capture;
    logic done;
  } seqStb_t;

  function automatic int unsigned cyclesFor(input int unsigned ns, input int unsigned clkNs);
    int unsigned c;
    c = (ns + clkNs - 1) / clkNs;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned maxOf(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/async_sram_seq_ctrl.sv
module async_sram_seq_ctrl
  import async_sram_seq_pkg::*;
#(
  parameter int unsigned RD_CYC   = 7,
  parameter int unsigned WR_CYC   = 7,
  parameter int unsigned HOLD_CYC = 1,
  parameter int unsigned TURN_CYC = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    hostReq,
  input  logic    hostWr,
  input  logic    pwrHold,
  output logic    hostReady,
  output seqStb_t stb
);

  localparam int unsigned MAX_CYC = maxOf(maxOf(RD_CYC, WR_CYC), maxOf(HOLD_CYC, TURN_CYC));
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

  seqState_t state, nextState;
  logic [CNT_W-1:0] cnt, nextCnt;
  logic accept;
  logic lastCyc;

  assign hostReady = (state == S_IDLE) && !pwrHold;
  assign accept    = hostReq && hostReady;
  assign lastCyc   = (cnt == '0);

  always_comb begin
    nextState = state;
    nextCnt   = cnt;
    unique case (state)
      S_IDLE: begin
        if (accept) begin
          if (hostWr) begin
            nextState = S_WR_PULSE;
            nextCnt   = CNT_W'(WR_CYC - 1);
          end else begin
            nextState = S_RD_ACC;
            nextCnt   = CNT_W'(RD_CYC - 1);
          end
        end
      end
      S_RD_ACC: begin
        if (lastCyc) begin
          nextState = S_RD_TURN;
          nextCnt   = CNT_W'(TURN_CYC - 1);
        end else begin
          nextCnt = cnt - 1'b1;
        end
      end
      S_RD_TURN: begin
        if (lastCyc) nextState = S_IDLE;
        else         nextCnt   = cnt - 1'b1;
      end
      S_WR_PULSE: begin
        if (lastCyc) begin
          nextState = S_WR_HOLD;
          nextCnt   = CNT_W'(HOLD_CYC - 1);
        end else begin
          nextCnt = cnt - 1'b1;
        end
      end
      S_WR_HOLD: begin
        if (lastCyc) nextState = S_IDLE;
        else         nextCnt   = cnt - 1'b1;
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_comb begin
    stb.load    = accept;
    stb.ceN     = !((nextState == S_RD_ACC) || (nextState == S_WR_PULSE));
    stb.oeN     = !(nextState == S_RD_ACC);
    stb.weN     = !(nextState == S_WR_PULSE);
    stb.drive   = (nextState == S_WR_PULSE) || (nextState == S_WR_HOLD);
    stb.capture = (state == S_RD_ACC) && lastCyc;
    stb.done    = ((state == S_RD_ACC) || (state == S_WR_HOLD)) && lastCyc;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else begin
      state <= nextState;
      cnt   <= nextCnt;
    end
  end

  // R7: hold input refuses requests
  p_refuse_protect_r7: assert property (@(posedge clk) disable iff (!rstN)
    pwrHold |-> !hostReady);

  // R7: no acceptance while an access is in flight
  p_busy_not_ready_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state != S_IDLE) |-> !hostReady);

  // R8: an access in flight never drops straight back to idle from its strobe phase
  p_finish_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_WR_PULSE) |=> (state == S_WR_PULSE) || (state == S_WR_HOLD));

endmodule

// File: rtl/async_sram_seq_dpath.sv
module async_sram_seq_dpath
  import async_sram_seq_pkg::*;
#(
  parameter int unsigned ADDR_W   = 19,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned RD_CYC   = 7,
  parameter int unsigned WR_CYC   = 7,
  parameter int unsigned HOLD_CYC = 1,
  parameter int unsigned TURN_CYC = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStb_t           stb,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic [DATA_W-1:0] memDin,
  output logic              hostAck,
  output logic [DATA_W-1:0] hostRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDout,
  output logic              memDoutEn,
  output logic              memCeN,
  output logic              memOeN,
  output logic              memWeN
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memAddr   <= '0;
      memDout   <= '0;
      memDoutEn <= 1'b0;
      memCeN    <= 1'b1;
      memOeN    <= 1'b1;
      memWeN    <= 1'b1;
      hostRdata <= '0;
      hostAck   <= 1'b0;
    end else begin
      memCeN    <= stb.ceN;
      memOeN    <= stb.oeN;
      memWeN    <= stb.weN;
      memDoutEn <= stb.drive;
      hostAck   <= stb.done;
      if (stb.load) begin
        memAddr <= hostAddr;
        memDout <= hostWdata;
      end
      if (stb.capture) hostRdata <= memDin;
    end
  end

  // Checker counters for pin-level windows
  localparam int unsigned CW = 16;
  localparam logic [CW-1:0] SAT = '1;
  logic [CW-1:0] weLow, oeLow, holdRun, oeHigh;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      weLow   <= '0;
      oeLow   <= '0;
      holdRun <= '0;
      oeHigh  <= SAT;
    end else begin
      weLow   <= !memWeN ? ((weLow == SAT) ? SAT : weLow + 1'b1) : '0;
      oeLow   <= !memOeN ? ((oeLow == SAT) ? SAT : oeLow + 1'b1) : '0;
      if (memDoutEn && memWeN) holdRun <= (holdRun == SAT) ? SAT : holdRun + 1'b1;
      else if (!memDoutEn)     holdRun <= '0;
      oeHigh  <= memOeN ? ((oeHigh == SAT) ? SAT : oeHigh + 1'b1) : '0;
    end
  end

  p_oe_high_write_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!memWeN || memDoutEn) |-> memOeN);

  p_we_width_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> (weLow == CW'(WR_CYC)));

  p_read_width_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memOeN) |-> (oeLow == CW'(RD_CYC)));

  p_hold_len_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memDoutEn) |-> (holdRun == CW'(HOLD_CYC)));

  p_addr_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    ((!memCeN || memDoutEn) && $past(!memCeN || memDoutEn)) |-> $stable(memAddr));

  p_turnaround_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memDoutEn) |-> (oeHigh >= CW'(TURN_CYC)));

  p_ack_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    hostAck |=> !hostAck);

endmodule

// File: rtl/async_sram_seq.sv
module async_sram_seq
  import async_sram_seq_pkg::*;
#(
  parameter int unsigned ADDR_W      = 19,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned CLK_NS      = 10,
  parameter int unsigned T_ACC_NS    = 70,
  parameter int unsigned T_OE_ACC_NS = 35,
  parameter int unsigned T_CYC_NS    = 70,
  parameter int unsigned T_WP_NS     = 55,
  parameter int unsigned T_AW_NS     = 65,
  parameter int unsigned T_DW_NS     = 30,
  parameter int unsigned T_DH_NS     = 0,
  parameter int unsigned T_AH_NS     = 5,
  parameter int unsigned T_OHZ_NS    = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostReq,
  input  logic              hostWr,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic              pwrHold,
  output logic              hostReady,
  output logic              hostAck,
  output logic [DATA_W-1:0] hostRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDout,
  output logic              memDoutEn,
  input  logic [DATA_W-1:0] memDin,
  output logic              memCeN,
  output logic              memOeN,
  output logic              memWeN
);

  localparam int unsigned CYC_MIN  = cyclesFor(T_CYC_NS, CLK_NS);
  localparam int unsigned RD_CYC   = maxOf(maxOf(cyclesFor(T_ACC_NS, CLK_NS),
                                                 cyclesFor(T_OE_ACC_NS, CLK_NS)), CYC_MIN);
  localparam int unsigned HOLD_CYC = maxOf(cyclesFor(T_DH_NS, CLK_NS), cyclesFor(T_AH_NS, CLK_NS));
  localparam int unsigned WR_REST  = (CYC_MIN > HOLD_CYC) ? (CYC_MIN - HOLD_CYC) : 1;
  localparam int unsigned WR_CYC   = maxOf(maxOf(cyclesFor(T_WP_NS, CLK_NS), cyclesFor(T_AW_NS, CLK_NS)),
                                           maxOf(cyclesFor(T_DW_NS, CLK_NS), WR_REST));
  localparam int unsigned TURN_CYC = cyclesFor(T_OHZ_NS, CLK_NS);

  seqStb_t stb;

  async_sram_seq_ctrl #(
    .RD_CYC(RD_CYC), .WR_CYC(WR_CYC), .HOLD_CYC(HOLD_CYC), .TURN_CYC(TURN_CYC)
  ) ctrl (
    .clk(clk), .rstN(rstN), .hostReq(hostReq), .hostWr(hostWr),
    .pwrHold(pwrHold), .hostReady(hostReady), .stb(stb)
  );

  async_sram_seq_dpath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .RD_CYC(RD_CYC), .WR_CYC(WR_CYC), .HOLD_CYC(HOLD_CYC), .TURN_CYC(TURN_CYC)
  ) dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .hostAddr(hostAddr), .hostWdata(hostWdata),
    .memDin(memDin), .hostAck(hostAck), .hostRdata(hostRdata), .memAddr(memAddr),
    .memDout(memDout), .memDoutEn(memDoutEn), .memCeN(memCeN), .memOeN(memOeN),
    .memWeN(memWeN)
  );

endmodule

// File: tb/tb_async_sram_seq.sv
module tb_async_sram_seq;

  localparam int CLK_NS = 10;
  function automatic int cyc(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction
  // Expected phase lengths from the requirement formulas, defaults 70/35/70/55/65/30/0/5/20 ns
  localparam int HOLD_E = (cyc(0) > cyc(5)) ? cyc(0) : cyc(5);
  localparam int RD_E   = 7;
  localparam int WR_E   = 7;
  localparam int TURN_E = 2;

  logic clk = 0;
  logic rstN = 0;
  logic hostReq = 0, hostWr = 0, pwrHold = 0;
  logic [18:0] hostAddr = '0;
  logic [7:0] hostWdata = '0;
  logic hostReady, hostAck, memDoutEn, memCeN, memOeN, memWeN;
  logic [7:0] hostRdata, memDout, memDin;
  logic [18:0] memAddr;

  always #5 clk = ~clk;

  async_sram_seq dut (
    .clk(clk), .rstN(rstN), .hostReq(hostReq), .hostWr(hostWr), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .pwrHold(pwrHold), .hostReady(hostReady), .hostAck(hostAck),
    .hostRdata(hostRdata), .memAddr(memAddr), .memDout(memDout), .memDoutEn(memDoutEn),
    .memDin(memDin), .memCeN(memCeN), .memOeN(memOeN), .memWeN(memWeN)
  );

  // Memory model: data only valid after RD_E cycles of both enables low
  logic [7:0] mem [256];
  int accLow = 0;
  assign memDin = (accLow >= RD_E) ? mem[memAddr[7:0]] : 8'hEE;

  // Pin monitors: record violations and event lengths
  int weLow = 0, oeLow = 0, holdRun = 0, sinceOe = 1000;
  int weBad = 0, weEvents = 0, oeBad = 0, oeEvents = 0, holdBad = 0, holdEvents = 0;
  int oeInWrite = 0, addrMoved = 0, turnBad = 0, ceLowCount = 0;
  logic prevWeN = 1, prevOeN = 1, prevEn = 0, prevActive = 0;
  logic [18:0] prevAddr = '0;

  initial for (int i = 0; i < 256; i++) mem[i] = 8'h00;

  always @(negedge clk) begin
    if (!memCeN && !memOeN) accLow = accLow + 1; else accLow = 0;
    if (!memCeN && !memWeN) mem[memAddr[7:0]] = memDout;
    if (!memCeN) ceLowCount = ceLowCount + 1;
    if ((!memWeN || memDoutEn) && !memOeN) oeInWrite = oeInWrite + 1;
    if (!memWeN) weLow = weLow + 1;
    if (memWeN && !prevWeN) begin weEvents++; if (weLow != WR_E) weBad++; weLow = 0; end
    if (!memOeN) oeLow = oeLow + 1;
    if (memOeN && !prevOeN) begin oeEvents++; if (oeLow != RD_E) oeBad++; oeLow = 0; end
    if (memDoutEn && memWeN) holdRun = holdRun + 1;
    if (!memDoutEn && prevEn) begin holdEvents++; if (holdRun != HOLD_E) holdBad++; holdRun = 0; end
    if (memDoutEn && !prevEn && sinceOe < TURN_E) turnBad++;
    if (!memOeN) sinceOe = 0; else if (sinceOe < 1000) sinceOe = sinceOe + 1;
    if ((!memCeN || memDoutEn) && prevActive && memAddr != prevAddr) addrMoved++;
    prevActive = !memCeN || memDoutEn;
    prevAddr = memAddr; prevWeN = memWeN; prevOeN = memOeN; prevEn = memDoutEn;
  end

  int nChecks = 0, nFail = 0;
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic doOp(input bit wr, input logic [18:0] a, input logic [7:0] d,
                      output logic [7:0] rd, output int lat);
    @(negedge clk);
    while (!hostReady) @(negedge clk);
    hostReq = 1; hostWr = wr; hostAddr = a; hostWdata = d;
    @(negedge clk);
    hostReq = 0;
    lat = 1;
    while (!hostAck && lat < 300) begin @(negedge clk); lat++; end
    rd = hostRdata;
    @(negedge clk);
    chk(!hostAck, "R9 ack one cycle", int'(hostAck), 0);
  endtask

  typedef struct packed { logic wr; logic [18:0] a; logic [7:0] d; } vec_t;
  localparam vec_t VEC [8] = '{
    '{1'b1, 19'h00012, 8'hA5},
    '{1'b1, 19'h7FF34, 8'h3C},
    '{1'b0, 19'h00012, 8'hA5},
    '{1'b1, 19'h00056, 8'hFF},
    '{1'b0, 19'h7FF34, 8'h3C},
    '{1'b0, 19'h00056, 8'hFF},
    '{1'b1, 19'h00012, 8'h00},
    '{1'b0, 19'h00012, 8'h00}
  };

  initial begin
    logic [7:0] rd;
    int lat;
    int ceBefore;
    // R1 during and after reset
    repeat (3) @(negedge clk);
    chk(memCeN && memOeN && memWeN && !memDoutEn && !hostAck, "R1 pins in reset",
        {memCeN, memOeN, memWeN, memDoutEn, hostAck}, 5'b11100);
    rstN = 1;
    @(negedge clk);
    chk(memCeN && memOeN && memWeN && !memDoutEn && !hostAck, "R1 pins after reset",
        {memCeN, memOeN, memWeN, memDoutEn, hostAck}, 5'b11100);
    chk(hostReady, "R1 ready", int'(hostReady), 1);

    // Table walk
    foreach (VEC[i]) begin
      doOp(VEC[i].wr, VEC[i].a, VEC[i].d, rd, lat);
      if (VEC[i].wr) begin
        chk(lat == WR_E + HOLD_E + 1, "R10 write latency", lat, WR_E + HOLD_E + 1);
      end else begin
        chk(lat == RD_E + 1, "R2 read latency", lat, RD_E + 1);
        chk(rd == VEC[i].d, "R9 read data", rd, VEC[i].d);
      end
    end

    // R7: requests under pwrHold are refused
    @(negedge clk);
    pwrHold = 1; hostReq = 1; hostWr = 1; hostAddr = 19'h00099; hostWdata = 8'h77;
    ceBefore = ceLowCount;
    repeat (6) begin
      @(negedge clk);
      chk(!hostReady, "R7 ready low under hold", int'(hostReady), 0);
    end
    hostReq = 0;
    chk(ceLowCount == ceBefore, "R7 no memory access under hold", ceLowCount, ceBefore);
    pwrHold = 0;
    doOp(1'b0, 19'h00099, 8'h00, rd, lat);
    chk(rd == 8'h00, "R7 refused write not stored", rd, 8'h00);

    // R7: request held during a busy read is ignored
    @(negedge clk);
    while (!hostReady) @(negedge clk);
    hostReq = 1; hostWr = 0; hostAddr = 19'h7FF34;
    @(negedge clk);
    hostWr = 1; hostAddr = 19'h000CD; hostWdata = 8'h11;
    repeat (3) @(negedge clk);
    hostReq = 0;
    lat = 0;
    while (!hostAck && lat < 300) begin @(negedge clk); lat++; end
    chk(hostRdata == 8'h3C, "R9 read during busy request", hostRdata, 8'h3C);
    doOp(1'b0, 19'h000CD, 8'h00, rd, lat);
    chk(rd == 8'h00, "R7 busy request not stored", rd, 8'h00);

    // R8: hold raised after accept does not abort the write
    @(negedge clk);
    while (!hostReady) @(negedge clk);
    hostReq = 1; hostWr = 1; hostAddr = 19'h000AB; hostWdata = 8'h5A;
    @(negedge clk);
    hostReq = 0; pwrHold = 1; lat = 1;
    while (!hostAck && lat < 300) begin @(negedge clk); lat++; end
    chk(lat == WR_E + HOLD_E + 1, "R8 write completes under hold", lat, WR_E + HOLD_E + 1);
    chk(!hostReady, "R8 ready low after completion under hold", int'(hostReady), 0);
    pwrHold = 0;
    doOp(1'b0, 19'h000AB, 8'h00, rd, lat);
    chk(rd == 8'h5A, "R8 data written under hold", rd, 8'h5A);

    // Write immediately after read to exercise turnaround
    doOp(1'b0, 19'h00056, 8'h00, rd, lat);
    doOp(1'b1, 19'h00056, 8'h81, rd, lat);
    doOp(1'b0, 19'h00056, 8'h00, rd, lat);
    chk(rd == 8'h81, "R9 read after back-to-back write", rd, 8'h81);

    repeat (4) @(negedge clk);
    chk(weBad == 0 && weEvents > 0, "R3 write strobe width", weBad, 0);
    chk(oeInWrite == 0, "R3 output enable high in write", oeInWrite, 0);
    chk(oeBad == 0 && oeEvents > 0, "R2 read strobe width", oeBad, 0);
    chk(holdBad == 0 && holdEvents > 0, "R4 data hold after write", holdBad, 0);
    chk(addrMoved == 0, "R5 address stable in cycle", addrMoved, 0);
    chk(turnBad == 0, "R6 bus turnaround", turnBad, 0);
    chk(HOLD_E == 1, "R10 zero-ns hold gives one cycle", HOLD_E, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks + 1, nFail + 1);
    $finish;
  end

endmodule